// File: doc/BRIEF.md
# USB Frame Interval Timer

This block keeps frame time for a USB host controller. A 14-bit down-counter tracks how many bit times remain in the current frame. It steps once per bit-time tick while the controller is operational. When it is at zero on a tick, it reloads from the programmed interval, advances a 16-bit frame number and raises a one-cycle start-of-frame pulse. A second pulse marks the point in the frame where periodic traffic may begin. A third pulse marks each change of the frame number's top bit.

Software programs the interval register, which holds the interval and a maximum packet size. Every write of that register flips a flag bit, and the flag is copied into the remaining-count register only when the count rolls over. Software can therefore compare the two flags to see whether a new interval is already in force. Two threshold registers are also held here: the periodic start point and the low-speed threshold. The low-speed threshold is stored for a scheduler elsewhere and is not used inside the block.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the interval field is FI_RESET (default 11999), the packet-size field is PK_RESET (default 10104), both flag bits are 0, the remaining count equals FI_RESET, the frame number and both thresholds are 0, and no pulse is high.
- R2: A write of the interval register does three things one cycle later. It stores data bits 13:0 as the interval and bits 30:16 as the packet size. Readback bits 15:14 are 0. The written bit 31 is ignored, and readback bit 31 inverts on every such write.
- R3: While run_en is low, the remaining count takes the interval value present in the previous cycle, the frame number holds, and no start-of-frame pulse occurs.
- R4: While run_en is high, each cycle with bit_tick high lowers a nonzero remaining count by one. Cycles without bit_tick leave the count and the frame number unchanged.
- R5: A tick while the remaining count is zero has three effects in the next cycle. The count reloads from the interval, the frame number increments modulo 2^16, and sof_pulse is high for exactly that cycle.
- R6: Remaining-count bit 31 takes the interval register's bit 31 only at that reload. An interval write alone leaves it unchanged.
- R7: fno_pulse is high together with sof_pulse exactly when the new frame number's bit 15 differs from the previous value. This happens at 0x7FFF→0x8000 and at 0xFFFF→0x0000.
- R8: pstart_pulse is high for one cycle when a decrement lands the remaining count on the periodic threshold. A reload never raises it.
- R9: A threshold write stores the periodic threshold (14 bits) or the low-speed threshold (12 bits), and it reads back one cycle later.
- R10: Remaining-count bits 30:14 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Controller operational; counting allowed |
| bit_tick | input | 1 | One-cycle bit-time enable |
| ival_wr | input | 1 | Interval register write strobe |
| ival_wdata | input | 32 | Interval register write data |
| pthr_wr | input | 1 | Periodic threshold write strobe |
| pthr_wdata | input | 14 | Periodic threshold write data |
| lthr_wr | input | 1 | Low-speed threshold write strobe |
| lthr_wdata | input | 12 | Low-speed threshold write data |
| ival_q | output | 32 | Interval register readback |
| remain_q | output | 32 | Remaining-count register readback |
| frame_num | output | 16 | Current frame number |
| pthr_q | output | 14 | Periodic threshold readback |
| lthr_q | output | 12 | Low-speed threshold readback |
| sof_pulse | output | 1 | Start of frame, one cycle |
| fno_pulse | output | 1 | Frame number top-bit change, one cycle |
| pstart_pulse | output | 1 | Periodic start point reached, one cycle |

## Verification
The hardest condition to reach is the frame-number overflow: bit 15 changes only after 32768 frames, and the default interval makes each frame thousands of cycles long. The stimulus programs an interval of zero and holds the tick high. Every cycle is then a complete frame, and 65536 consecutive frames cross both the 0x7FFF→0x8000 and the 0xFFFF→0x0000 boundaries in about 66k cycles. Each of those frames is compared against a queued expected frame number, and the overflow pulse is predicted from that number.

// File: rtl/frm_pkg.sv
package frm_pkg;

    localparam int REG_W   = 32;
    localparam int IV_W    = 14;
    localparam int PK_W    = 15;
    localparam int PK_LSB  = 16;
    localparam int TOG_BIT = REG_W - 1;
    localparam int FN_W    = 16;
    localparam int LS_W    = 12;
    localparam int IV_GAP  = PK_LSB - IV_W;
    localparam int RM_GAP  = REG_W - 1 - IV_W;

    typedef struct packed {
        logic            tog;
        logic [PK_W-1:0] pkt;
        logic [IV_W-1:0] ival;
        logic [IV_W-1:0] pthr;
        logic [LS_W-1:0] lthr;
    } cfg_st_t;

    typedef struct packed {
        logic            tog;
        logic [IV_W-1:0] cnt;
        logic            per;
    } rem_st_t;

    typedef struct packed {
        logic [FN_W-1:0] num;
        logic            sof;
        logic            ovf;
    } num_st_t;

endpackage

// File: rtl/frm_cfg_regs.sv
module frm_cfg_regs
    import frm_pkg::*;
#(
    parameter logic [IV_W-1:0] FI_RESET = 14'd11999,
    parameter logic [PK_W-1:0] PK_RESET = 15'd10104
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ival_wr,
    input  logic [REG_W-1:0] ival_wdata,
    input  logic             pthr_wr,
    input  logic [IV_W-1:0]  pthr_wdata,
    input  logic             lthr_wr,
    input  logic [LS_W-1:0]  lthr_wdata,
    output logic             ival_tog,
    output logic [PK_W-1:0]  ival_pkt,
    output logic [IV_W-1:0]  ival_val,
    output logic [IV_W-1:0]  pthr_val,
    output logic [LS_W-1:0]  lthr_val
);

    cfg_st_t st_d, st_q;
    logic    wdata_unused;

    // write data bits that carry no state: flag position and reserved gap
    assign wdata_unused = ^{ival_wdata[TOG_BIT], ival_wdata[PK_LSB-1:IV_W]};

    always_comb begin
        st_d = st_q;
        if (ival_wr) begin
            st_d.ival = ival_wdata[IV_W-1:0];
            st_d.pkt  = ival_wdata[PK_LSB +: PK_W];
            st_d.tog  = ~st_q.tog;
        end
        if (pthr_wr) begin
            st_d.pthr = pthr_wdata;
        end
        if (lthr_wr) begin
            st_d.lthr = lthr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tog  <= 1'b0;
            st_q.pkt  <= PK_RESET;
            st_q.ival <= FI_RESET;
            st_q.pthr <= '0;
            st_q.lthr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ival_tog = st_q.tog;
    assign ival_pkt = st_q.pkt;
    assign ival_val = st_q.ival;
    assign pthr_val = st_q.pthr;
    assign lthr_val = st_q.lthr;

endmodule

// File: rtl/frm_remain_ctr.sv
module frm_remain_ctr
    import frm_pkg::*;
#(
    parameter logic [IV_W-1:0] FI_RESET = 14'd11999
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            bit_tick,
    input  logic [IV_W-1:0] ival_val,
    input  logic            ival_tog,
    input  logic [IV_W-1:0] pthr_val,
    output logic [IV_W-1:0] cnt,
    output logic            cnt_tog,
    output logic            wrap,
    output logic            per_pulse
);

    rem_st_t         st_d, st_q;
    logic [IV_W-1:0] cnt_dec;

    assign cnt_dec = st_q.cnt - 1'b1;
    assign wrap    = run_en && bit_tick && (st_q.cnt == '0);

    always_comb begin
        st_d     = st_q;
        st_d.per = 1'b0;
        if (!run_en) begin
            st_d.cnt = ival_val;
        end else if (bit_tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = ival_val;
                st_d.tog = ival_tog;
            end else begin
                st_d.cnt = cnt_dec;
                st_d.per = (cnt_dec == pthr_val);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tog <= 1'b0;
            st_q.cnt <= FI_RESET;
            st_q.per <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt       = st_q.cnt;
    assign cnt_tog   = st_q.tog;
    assign per_pulse = st_q.per;

endmodule

// File: rtl/frm_num_ctr.sv
module frm_num_ctr
    import frm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wrap,
    output logic [FN_W-1:0] num,
    output logic            sof,
    output logic            ovf
);

    num_st_t         st_d, st_q;
    logic [FN_W-1:0] num_inc;

    assign num_inc = st_q.num + 1'b1;

    always_comb begin
        st_d     = st_q;
        st_d.sof = wrap;
        st_d.ovf = wrap && (num_inc[FN_W-1] != st_q.num[FN_W-1]);
        if (wrap) begin
            st_d.num = num_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign num = st_q.num;
    assign sof = st_q.sof;
    assign ovf = st_q.ovf;

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import frm_pkg::*;
#(
    parameter logic [IV_W-1:0] FI_RESET = 14'd11999,
    parameter logic [PK_W-1:0] PK_RESET = 15'd10104
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             bit_tick,
    input  logic             ival_wr,
    input  logic [REG_W-1:0] ival_wdata,
    input  logic             pthr_wr,
    input  logic [IV_W-1:0]  pthr_wdata,
    input  logic             lthr_wr,
    input  logic [LS_W-1:0]  lthr_wdata,
    output logic [REG_W-1:0] ival_q,
    output logic [REG_W-1:0] remain_q,
    output logic [FN_W-1:0]  frame_num,
    output logic [IV_W-1:0]  pthr_q,
    output logic [LS_W-1:0]  lthr_q,
    output logic             sof_pulse,
    output logic             fno_pulse,
    output logic             pstart_pulse
);

    logic            ival_tog;
    logic [PK_W-1:0] ival_pkt;
    logic [IV_W-1:0] ival_val;
    logic [IV_W-1:0] cnt;
    logic            cnt_tog;
    logic            wrap;

    frm_cfg_regs #(
        .FI_RESET (FI_RESET),
        .PK_RESET (PK_RESET)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ival_wr    (ival_wr),
        .ival_wdata (ival_wdata),
        .pthr_wr    (pthr_wr),
        .pthr_wdata (pthr_wdata),
        .lthr_wr    (lthr_wr),
        .lthr_wdata (lthr_wdata),
        .ival_tog   (ival_tog),
        .ival_pkt   (ival_pkt),
        .ival_val   (ival_val),
        .pthr_val   (pthr_q),
        .lthr_val   (lthr_q)
    );

    frm_remain_ctr #(
        .FI_RESET (FI_RESET)
    ) u_rem (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .bit_tick  (bit_tick),
        .ival_val  (ival_val),
        .ival_tog  (ival_tog),
        .pthr_val  (pthr_q),
        .cnt       (cnt),
        .cnt_tog   (cnt_tog),
        .wrap      (wrap),
        .per_pulse (pstart_pulse)
    );

    frm_num_ctr u_num (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (wrap),
        .num   (frame_num),
        .sof   (sof_pulse),
        .ovf   (fno_pulse)
    );

    assign ival_q   = {ival_tog, ival_pkt, {IV_GAP{1'b0}}, ival_val};
    assign remain_q = {cnt_tog, {RM_GAP{1'b0}}, cnt};

endmodule

// File: rtl/frm_timer_chk.sv
module frm_timer_chk
    import frm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             bit_tick,
    input logic             ival_wr,
    input logic [REG_W-1:0] ival_q,
    input logic [REG_W-1:0] remain_q,
    input logic [FN_W-1:0]  frame_num,
    input logic [IV_W-1:0]  pthr_q,
    input logic             sof_pulse,
    input logic             fno_pulse,
    input logic             pstart_pulse
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ival_q[PK_LSB-1:IV_W] == '0 && remain_q[REG_W-2:IV_W] == '0); // R10

    AST_WR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ival_wr |=> ival_q[TOG_BIT] != $past(ival_q[TOG_BIT])); // R2

    AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> remain_q[IV_W-1:0] == $past(ival_q[IV_W-1:0]) && !sof_pulse); // R3

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && !bit_tick |=> $stable(remain_q) && $stable(frame_num)); // R4

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && bit_tick && remain_q[IV_W-1:0] != '0
        |=> remain_q[IV_W-1:0] == $past(remain_q[IV_W-1:0]) - 14'd1); // R4

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && bit_tick && remain_q[IV_W-1:0] == '0
        |=> sof_pulse && remain_q[IV_W-1:0] == $past(ival_q[IV_W-1:0])
            && frame_num == $past(frame_num) + 16'd1); // R5

    AST_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_en && bit_tick && remain_q[IV_W-1:0] == '0)
        |=> $stable(remain_q[TOG_BIT])); // R6

    AST_FLAG_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && bit_tick && remain_q[IV_W-1:0] == '0
        |=> remain_q[TOG_BIT] == $past(ival_q[TOG_BIT])); // R6

    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fno_pulse |-> sof_pulse && frame_num[FN_W-2:0] == '0); // R7

    AST_PSTART_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pstart_pulse |-> remain_q[IV_W-1:0] == pthr_q && !sof_pulse); // R8

endmodule

bind usb_frame_timer frm_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .bit_tick     (bit_tick),
    .ival_wr      (ival_wr),
    .ival_q       (ival_q),
    .remain_q     (remain_q),
    .frame_num    (frame_num),
    .pthr_q       (pthr_q),
    .sof_pulse    (sof_pulse),
    .fno_pulse    (fno_pulse),
    .pstart_pulse (pstart_pulse)
);

// File: tb/usb_frame_timer_tb.sv
`timescale 1ns/1ps
module usb_frame_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        bit_tick = 1'b0;
    logic        ival_wr = 1'b0;
    logic [31:0] ival_wdata = '0;
    logic        pthr_wr = 1'b0;
    logic [13:0] pthr_wdata = '0;
    logic        lthr_wr = 1'b0;
    logic [11:0] lthr_wdata = '0;
    logic [31:0] ival_q;
    logic [31:0] remain_q;
    logic [15:0] frame_num;
    logic [13:0] pthr_q;
    logic [11:0] lthr_q;
    logic        sof_pulse;
    logic        fno_pulse;
    logic        pstart_pulse;

    int          vecs = 0;
    int          errs = 0;
    int          fno_cnt = 0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;

    usb_frame_timer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .bit_tick     (bit_tick),
        .ival_wr      (ival_wr),
        .ival_wdata   (ival_wdata),
        .pthr_wr      (pthr_wr),
        .pthr_wdata   (pthr_wdata),
        .lthr_wr      (lthr_wr),
        .lthr_wdata   (lthr_wdata),
        .ival_q       (ival_q),
        .remain_q     (remain_q),
        .frame_num    (frame_num),
        .pthr_q       (pthr_q),
        .lthr_q       (lthr_q),
        .sof_pulse    (sof_pulse),
        .fno_pulse    (fno_pulse),
        .pstart_pulse (pstart_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_ival(input logic [31:0] d);
        ival_wr    = 1'b1;
        ival_wdata = d;
        step();
        ival_wr    = 1'b0;
    endtask

    // monitor: every start of frame pops the expected frame number
    always @(negedge clk) begin
        if (rst_n && fno_pulse) fno_cnt++;
        if (rst_n && fno_pulse && !sof_pulse) chk("R7 overflow without sof", 32'd1, 32'd0);
        if (rst_n && sof_pulse) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected sof", 32'd1, 32'd0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk("R5 frame number", {16'd0, frame_num}, {16'd0, e});
                chk("R7 overflow pulse", {31'd0, fno_pulse}, {31'd0, (e[14:0] == 15'd0)});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 interval", ival_q, {1'b0, 15'd10104, 2'b00, 14'd11999});
        chk("R1 remain", remain_q, 32'd11999);
        chk("R1 frame", {16'd0, frame_num}, 32'd0);
        chk("R1 pulses", {29'd0, sof_pulse, fno_pulse, pstart_pulse}, 32'd0);
        chk("R1 thresholds", {6'd0, pthr_q, lthr_q}, 32'd0);

        // R2 write: flag bit from data ignored, reserved bits dropped
        wr_ival(32'h8001_C00A);
        chk("R2 interval write", ival_q, 32'h8001_000A);
        step();
        chk("R3 idle follows interval", remain_q, 32'h0000_000A);
        wr_ival(32'h0000_000A);
        chk("R2 flag flips back", ival_q, 32'h0000_000A);
        wr_ival(32'h7FFF_0004);
        chk("R2 packet field", ival_q, 32'hFFFF_0004);
        step();
        chk("R6 flag not copied while idle", remain_q, 32'h0000_0004);

        // R9 thresholds
        pthr_wr = 1'b1; pthr_wdata = 14'd2;
        lthr_wr = 1'b1; lthr_wdata = 12'hABC;
        step();
        pthr_wr = 1'b0; lthr_wr = 1'b0;
        chk("R9 periodic threshold", {18'd0, pthr_q}, 32'd2);
        chk("R9 low-speed threshold", {20'd0, lthr_q}, 32'h0ABC);

        // R4 running without ticks
        run_en = 1'b1;
        repeat (3) step();
        chk("R4 hold without tick", remain_q, 32'h0000_0004);

        // first frame
        exp_q.push_back(16'd1);
        bit_tick = 1'b1;
        step();
        chk("R4 decrement", remain_q, 32'h0000_0003);
        chk("R8 no early pstart", {31'd0, pstart_pulse}, 32'd0);
        step();
        chk("R8 pstart at threshold", {31'd0, pstart_pulse}, 32'd1);
        chk("R4 decrement to 2", remain_q, 32'h0000_0002);
        step();
        chk("R8 pstart one cycle", {31'd0, pstart_pulse}, 32'd0);
        step();
        chk("R4 reach zero", remain_q, 32'h0000_0000);
        step();
        chk("R5 sof", {31'd0, sof_pulse}, 32'd1);
        chk("R6 flag copied at reload", remain_q, 32'h8000_0004);
        bit_tick = 1'b0;
        step();
        chk("R5 sof one cycle", {31'd0, sof_pulse}, 32'd0);
        chk("R4 hold after reload", remain_q, 32'h8000_0004);

        // new interval mid-frame: flag copied only at rollover
        wr_ival(32'h0000_0003);
        chk("R2 flag flips", ival_q, 32'h0000_0003);
        chk("R6 remain flag unchanged by write", remain_q, 32'h8000_0004);
        exp_q.push_back(16'd2);
        bit_tick = 1'b1;
        repeat (5) step();
        bit_tick = 1'b0;
        chk("R6 new interval and flag in force", remain_q, 32'h0000_0003);
        chk("R5 frame 2", {16'd0, frame_num}, 32'd2);

        // intermittent ticks
        bit_tick = 1'b1; step();
        bit_tick = 1'b0; step();
        bit_tick = 1'b1; step();
        bit_tick = 1'b0; step();
        chk("R4 intermittent ticks", remain_q, 32'h0000_0001);

        run_en = 1'b0;
        step();
        chk("R3 stop reloads interval", remain_q, 32'h0000_0003);
        chk("R3 frame held", {16'd0, frame_num}, 32'd2);

        // zero interval: one frame per tick, wrap the frame number
        wr_ival(32'h0000_0000);
        step();
        chk("R2 zero interval", ival_q, 32'h8000_0000);
        chk("R3 remain zero", remain_q, 32'h0000_0000);
        run_en   = 1'b1;
        bit_tick = 1'b1;
        for (int k = 0; k < 65536; k++) begin
            exp_q.push_back(16'(k + 3));
            step();
        end
        bit_tick = 1'b0;
        step();
        chk("R5 frame wrapped to start", {16'd0, frame_num}, 32'd2);
        chk("R7 two overflow pulses", fno_cnt, 32'd2);
        chk("R5 all frames seen", exp_q.size(), 32'd0);
        chk("R6 flag after wraps", remain_q, 32'h8000_0000);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule